// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block times the external memory bus of an 8-bit controller core that keeps all of its program in external memory. It runs on the oscillator clock. One machine cycle is twelve clocks: six states of two phases each, and each half-cycle is six clocks. It puts the low address byte and then the data byte on one 8-pin port (P0), and the high address byte on a second port (P2). It pulses an address latch enable so that an external latch can capture the low address.

For instruction fetches, each half-cycle can carry one fetch, marked by an active-low program strobe. For data memory, a request takes a whole machine cycle and uses separate active-low read and write strobes. During that cycle the second address latch pulse and both program strobes are dropped. The high port carries either the pointer's upper byte or the value of the core's port latch, depending on the addressing width of the access.

The core follows the cycle through `state_o` and `phase_o`. The block samples a fetch request at the last clock of each half-cycle, and a data request only at the last clock of the machine cycle. Fetched and read bytes come back with one-clock valid pulses.

Top module: `ext_bus_seq`

Clock numbers below are 0 to 11 within the machine cycle, counted in the cycle that follows the sampling edge. "Position" is 0 to 5 within a half-cycle. Half A covers clocks 0 to 5 and half B covers clocks 6 to 11.

## Requirements
- R1: A cycle counter runs 0 to 11 and wraps. `state_o` equals counter/2 and `phase_o` equals counter mod 2. The first clock after reset release is counter 0.
- R2: When no data access is active, `ale_o` is high at positions 0 and 1 of every half-cycle and low elsewhere. This gives two pulses per machine cycle, whether or not fetches occur.
- R3: In a data cycle, `ale_o` pulses at clocks 0 and 1 with the data address on P0. The half-B pulse (clocks 6 and 7) is suppressed.
- R4: In a fetch half, `psen_no` is low at positions 3 and 4 and high elsewhere. `psen_no` stays high in a half-cycle that has no fetch.
- R5: In a data cycle, `psen_no` stays high for all twelve clocks, even if `fetch_req_i` is high at the mid-cycle sample.
- R6: In a fetch half, P0 drives `fetch_addr_i[7:0]` at positions 0 to 2 and is released at positions 3 to 5. P0 is released in a half-cycle with no fetch and no data access. `p0_i` is captured at the end of position 4, and `fetch_data_o` carries it with `fetch_valid_o` high during position 5.
- R7: `p2_o` shows the fetch address's upper byte in a fetch half. In a data cycle with `dacc_wide_i`=1 it shows `dacc_addr_i[15:8]`; with `dacc_wide_i`=0 it shows `p2_latch_i`. In a half-cycle with no access it shows `p2_latch_i`.
- R8: In a read cycle (`dacc_we_i`=0), `rd_no` is low at clocks 3 to 10 and P0 is released from clock 3 onward. `p0_i` is captured at the end of clock 10 and shown on `dacc_rdata_o`, with `dacc_valid_o` high at clock 11.
- R9: In a write cycle (`dacc_we_i`=1), `wr_no` is low at clocks 3 to 10, and P0 drives `dacc_wdata_i` at clocks 3 to 11.
- R10: A data request is taken only at the machine-cycle boundary (counter 11). A request present at the mid-cycle sample (counter 5) has no effect on the strobes.
- R11: While `rst_ni` is low, `ale_o` is low, all three strobes are high, P0 is released and both valid outputs are low.
- R12: No two of `psen_no`, `rd_no` and `wr_no` are low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_req_i | input | 1 | Fetch wanted in the next half-cycle |
| fetch_addr_i | input | 16 | Fetch address |
| dacc_req_i | input | 1 | Data access wanted in the next machine cycle |
| dacc_we_i | input | 1 | 1 = write, 0 = read |
| dacc_wide_i | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit indirect |
| dacc_addr_i | input | 16 | Data address |
| dacc_wdata_i | input | 8 | Write data |
| p2_latch_i | input | 8 | Core's high-port latch value |
| p0_i | input | 8 | Low port pin input |
| state_o | output | 3 | Current state 0..5 |
| phase_o | output | 1 | Current phase 0..1 |
| fetch_data_o | output | 8 | Fetched byte |
| fetch_valid_o | output | 1 | Fetched byte valid pulse |
| dacc_rdata_o | output | 8 | Read data byte |
| dacc_valid_o | output | 1 | Read data valid pulse |
| ale_o | output | 1 | Address latch enable |
| psen_no | output | 1 | Program strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| p0_o | output | 8 | Low port drive value |
| p0_oe_o | output | 1 | Low port drive enable |
| p2_o | output | 8 | High port value |

## Verification
The assertions check on every clock that:
- the counter steps and wraps;
- the three strobes never overlap;
- no program strobe occurs in a data cycle and the half-B latch pulse is dropped there;
- P0 is released under the read strobe and driven under the write strobe;
- a data cycle cannot start or end mid-cycle.

Only the bench scenarios can show the rest:
- the exact clock positions of every edge;
- which byte lands on each port for fetch, wide and narrow data accesses;
- that each captured byte is the one present inside its strobe window, since the bench drives the inverted byte outside that window;
- that mid-cycle data requests and fetch requests inside a data cycle leave the bus untouched.

// File: rtl/ebs_pkg.sv
`timescale 1ns/1ps
package ebs_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              we;
    logic              wide;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } dacc_t;
endpackage

// File: rtl/ebs_timing.sv
`timescale 1ns/1ps
module ebs_timing #(
  parameter int unsigned STATES = 6,
  parameter int unsigned PHASES = 2,
  localparam int unsigned CYC = STATES * PHASES,
  localparam int unsigned HALF = CYC / 2,
  localparam int unsigned CW = $clog2(CYC),
  localparam int unsigned SW = $clog2(STATES),
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] pos_o,
  output logic          upper_o,
  output logic          cyc_last_o,
  output logic          half_last_o,
  output logic [SW-1:0] state_o,
  output logic [PW-1:0] phase_o
);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);
  localparam logic [CW-1:0] HLEN = CW'(HALF);

  logic [CW-1:0] cnt_q;

  // reset parks on the last clock so the first edge after release samples requests
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= LAST;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o       = cnt_q;
  assign upper_o     = (cnt_q >= HLEN);
  assign pos_o       = upper_o ? (cnt_q - HLEN) : cnt_q;
  assign cyc_last_o  = (cnt_q == LAST);
  assign half_last_o = (pos_o == HLEN - CW'(1));
  assign state_o     = SW'(cnt_q / CW'(PHASES));
  assign phase_o     = PW'(cnt_q % CW'(PHASES));

  p_cnt_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));
  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/ebs_slot_ctrl.sv
`timescale 1ns/1ps
module ebs_slot_ctrl
  import ebs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_last_i,
  input  logic              half_last_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              dacc_req_i,
  input  dacc_t             dacc_i,
  output logic              data_cyc_o,
  output dacc_t             dacc_o,
  output logic              fetch_act_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  logic              data_cyc_q;
  dacc_t             dacc_q;
  logic              fetch_act_q;
  logic [ADDR_W-1:0] fetch_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_cyc_q   <= 1'b0;
      dacc_q       <= '0;
      fetch_act_q  <= 1'b0;
      fetch_addr_q <= '0;
    end else if (cyc_last_i) begin
      data_cyc_q   <= dacc_req_i;
      if (dacc_req_i) dacc_q <= dacc_i;
      fetch_act_q  <= fetch_req_i && !dacc_req_i;
      fetch_addr_q <= fetch_addr_i;
    end else if (half_last_i) begin
      // a data cycle owns both halves: mid-cycle fetch requests are dropped
      fetch_act_q  <= fetch_req_i && !data_cyc_q;
      fetch_addr_q <= fetch_addr_i;
    end
  end

  assign data_cyc_o   = data_cyc_q;
  assign dacc_o       = dacc_q;
  assign fetch_act_o  = fetch_act_q;
  assign fetch_addr_o = fetch_addr_q;

  p_data_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_last_i |=> $stable(data_cyc_q));
  p_data_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_cyc_q |-> !fetch_act_q);
endmodule

// File: rtl/ebs_pin_mux.sv
`timescale 1ns/1ps
module ebs_pin_mux
  import ebs_pkg::*;
#(
  parameter int unsigned STATES = 6,
  parameter int unsigned PHASES = 2,
  localparam int unsigned CYC = STATES * PHASES,
  localparam int unsigned HALF = CYC / 2,
  localparam int unsigned CW = $clog2(CYC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     cnt_i,
  input  logic [CW-1:0]     pos_i,
  input  logic              upper_i,
  input  logic              data_cyc_i,
  input  dacc_t             dacc_i,
  input  logic              fetch_act_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [DATA_W-1:0] p2_latch_i,
  input  logic [DATA_W-1:0] p0_i,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] p0_o,
  output logic              p0_oe_o,
  output logic [DATA_W-1:0] p2_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] dacc_rdata_o,
  output logic              dacc_valid_o
);
  localparam logic [CW-1:0] ALE_END    = CW'(PHASES);
  localparam logic [CW-1:0] ADDR_LAST  = CW'(PHASES);
  localparam logic [CW-1:0] FSTB_FIRST = CW'(HALF / 2);
  localparam logic [CW-1:0] FSTB_LAST  = CW'(HALF - 2);
  localparam logic [CW-1:0] DSTB_FIRST = CW'(HALF / 2);
  localparam logic [CW-1:0] DSTB_LAST  = CW'(CYC - 2);

  logic f_win, d_win, d_addr_ph;

  assign f_win     = fetch_act_i && (pos_i >= FSTB_FIRST) && (pos_i <= FSTB_LAST);
  assign d_win     = data_cyc_i && (cnt_i >= DSTB_FIRST) && (cnt_i <= DSTB_LAST);
  assign d_addr_ph = (cnt_i <= ADDR_LAST);

  always_comb begin
    ale_o   = (pos_i < ALE_END) && !(data_cyc_i && upper_i);
    psen_no = !f_win;
    rd_no   = !(d_win && !dacc_i.we);
    wr_no   = !(d_win && dacc_i.we);
    p0_oe_o = 1'b0;
    p0_o    = '1;
    p2_o    = p2_latch_i;
    if (fetch_act_i) begin
      p0_oe_o = (pos_i <= ADDR_LAST);
      p0_o    = fetch_addr_i[DATA_W-1:0];
      p2_o    = fetch_addr_i[ADDR_W-1 -: DATA_W];
    end else if (data_cyc_i) begin
      p0_oe_o = d_addr_ph || dacc_i.we;
      p0_o    = d_addr_ph ? dacc_i.addr[DATA_W-1:0] : dacc_i.wdata;
      if (dacc_i.wide) p2_o = dacc_i.addr[ADDR_W-1 -: DATA_W];
    end
  end

  // capture just before the strobe rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_data_o  <= '0;
      fetch_valid_o <= 1'b0;
      dacc_rdata_o  <= '0;
      dacc_valid_o  <= 1'b0;
    end else begin
      fetch_valid_o <= fetch_act_i && (pos_i == FSTB_LAST);
      if (fetch_act_i && (pos_i == FSTB_LAST)) fetch_data_o <= p0_i;
      dacc_valid_o  <= data_cyc_i && !dacc_i.we && (cnt_i == DSTB_LAST);
      if (data_cyc_i && !dacc_i.we && (cnt_i == DSTB_LAST)) dacc_rdata_o <= p0_i;
    end
  end

  p_one_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!psen_no, !rd_no, !wr_no}) <= 1);
  p_ale_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_cyc_i && upper_i) |-> !ale_o);
  p_psen_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_cyc_i |-> psen_no);
  p_ale_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && (fetch_act_i || data_cyc_i)) |-> p0_oe_o);
  p_fvalid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> $past(!psen_no));
  p_rd_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !p0_oe_o);
  p_wr_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> p0_oe_o);
endmodule

// File: rtl/ext_bus_seq.sv
`timescale 1ns/1ps
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int unsigned STATES = 6,
  parameter int unsigned PHASES = 2,
  localparam int unsigned CW = $clog2(STATES * PHASES),
  localparam int unsigned SW = $clog2(STATES),
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              dacc_req_i,
  input  logic              dacc_we_i,
  input  logic              dacc_wide_i,
  input  logic [ADDR_W-1:0] dacc_addr_i,
  input  logic [DATA_W-1:0] dacc_wdata_i,
  input  logic [DATA_W-1:0] p2_latch_i,
  input  logic [DATA_W-1:0] p0_i,
  output logic [SW-1:0]     state_o,
  output logic [PW-1:0]     phase_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] dacc_rdata_o,
  output logic              dacc_valid_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] p0_o,
  output logic              p0_oe_o,
  output logic [DATA_W-1:0] p2_o
);
  logic [CW-1:0]     cnt, pos;
  logic              upper, cyc_last, half_last;
  logic              data_cyc, fetch_act;
  logic [ADDR_W-1:0] fetch_addr;
  dacc_t             dacc_in, dacc_cur;

  assign dacc_in = '{we: dacc_we_i, wide: dacc_wide_i, addr: dacc_addr_i, wdata: dacc_wdata_i};

  ebs_timing #(.STATES(STATES), .PHASES(PHASES)) u_timing (
    .clk_i, .rst_ni,
    .cnt_o(cnt), .pos_o(pos), .upper_o(upper),
    .cyc_last_o(cyc_last), .half_last_o(half_last),
    .state_o, .phase_o
  );

  ebs_slot_ctrl u_slot (
    .clk_i, .rst_ni,
    .cyc_last_i(cyc_last), .half_last_i(half_last),
    .fetch_req_i, .fetch_addr_i,
    .dacc_req_i, .dacc_i(dacc_in),
    .data_cyc_o(data_cyc), .dacc_o(dacc_cur),
    .fetch_act_o(fetch_act), .fetch_addr_o(fetch_addr)
  );

  ebs_pin_mux #(.STATES(STATES), .PHASES(PHASES)) u_pins (
    .clk_i, .rst_ni,
    .cnt_i(cnt), .pos_i(pos), .upper_i(upper),
    .data_cyc_i(data_cyc), .dacc_i(dacc_cur),
    .fetch_act_i(fetch_act), .fetch_addr_i(fetch_addr),
    .p2_latch_i, .p0_i,
    .ale_o, .psen_no, .rd_no, .wr_no, .p0_o, .p0_oe_o, .p2_o,
    .fetch_data_o, .fetch_valid_o, .dacc_rdata_o, .dacc_valid_o
  );
endmodule

// File: tb/ext_bus_seq_test.sv
`timescale 1ns/1ps
module ext_bus_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic fetch_req_i, dacc_req_i, dacc_we_i, dacc_wide_i;
  logic [15:0] fetch_addr_i, dacc_addr_i;
  logic [7:0] dacc_wdata_i, p2_latch_i, p0_i;
  logic [2:0] state_o;
  logic [0:0] phase_o;
  logic [7:0] fetch_data_o, dacc_rdata_o, p0_o, p2_o;
  logic fetch_valid_o, dacc_valid_o, ale_o, psen_no, rd_no, wr_no, p0_oe_o;

  ext_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i, .fetch_addr_i, .dacc_req_i, .dacc_we_i, .dacc_wide_i,
    .dacc_addr_i, .dacc_wdata_i, .p2_latch_i, .p0_i,
    .state_o, .phase_o, .fetch_data_o, .fetch_valid_o, .dacc_rdata_o, .dacc_valid_o,
    .ale_o, .psen_no, .rd_no, .wr_no, .p0_o, .p0_oe_o, .p2_o
  );

  int errors = 0;
  int checks = 0;

  typedef struct packed {
    logic f0, f1, dreq, we, wide;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  p2;
    logic [15:0] fa0;
  } cfg_t;

  localparam int NV = 11;
  localparam cfg_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,8'h3C,16'h0000}, // idle
    '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,8'h00,8'h3C,16'h1234}, // two fetches
    '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,8'h81,16'h8001}, // half A only
    '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,8'h00,8'h42,16'h00FF}, // half B only, carry
    '{1'b0,1'b1,1'b1,1'b0,1'b1,16'h5A6B,8'h00,8'h77,16'h2000}, // wide read, fetch req ignored
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h00C4,8'h00,8'h9E,16'h0000}, // narrow read
    '{1'b1,1'b1,1'b1,1'b1,1'b1,16'hABCD,8'hE1,8'h11,16'h3000}, // wide write
    '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0042,8'h7F,8'hC3,16'h0000}, // narrow write
    '{1'b0,1'b0,1'b1,1'b0,1'b1,16'hFFFF,8'h00,8'h00,16'h0000}, // back-to-back read
    '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,8'h00,8'h5A,16'hFFFF}, // fetch wrap
    '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,8'h3C,16'h0000}
  };

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive_first(input cfg_t c);
    fetch_req_i  = c.f0;
    fetch_addr_i = c.fa0;
    dacc_req_i   = c.dreq;
    dacc_we_i    = c.we;
    dacc_wide_i  = c.wide;
    dacc_addr_i  = c.addr;
    dacc_wdata_i = c.wdata;
    p2_latch_i   = c.p2;
  endtask

  task automatic idle_checks(input string req);
    chk(req, "ale", 16'(ale_o), 16'd0);
    chk(req, "psen_n", 16'(psen_no), 16'd1);
    chk(req, "rd_n", 16'(rd_no), 16'd1);
    chk(req, "wr_n", 16'(wr_no), 16'd1);
    chk(req, "p0_oe", 16'(p0_oe_o), 16'd0);
    chk(req, "fetch_valid", 16'(fetch_valid_o), 16'd0);
    chk(req, "dacc_valid", 16'(dacc_valid_o), 16'd0);
  endtask

  // one machine cycle of cfg c; n is presented for the following cycle
  task automatic run_cycle(input cfg_t c, input cfg_t n);
    for (int t = 0; t < 12; t++) begin
      logic h, fact, exp_oe, win_f, win_d;
      int k;
      logic [15:0] fa;
      logic [7:0] exp_p0, exp_p2, byte_v;
      @(negedge clk);
      h    = (t >= 6);
      k    = t % 6;
      fa   = h ? c.fa0 + 16'd1 : c.fa0;
      fact = !c.dreq && (h ? c.f1 : c.f0);
      win_f = fact && k >= 3 && k <= 4;
      win_d = c.dreq && t >= 3 && t <= 10;
      chk("R1", "state", 16'(state_o), 16'(t / 2));
      chk("R1", "phase", 16'(phase_o), 16'(t % 2));
      chk((c.dreq && h) ? "R3" : "R2", "ale", 16'(ale_o),
          16'(k < 2 && !(c.dreq && h)));
      chk(c.dreq ? "R5" : "R4", "psen_n", 16'(psen_no), 16'(!win_f));
      chk(c.dreq ? "R8" : "R10", "rd_n", 16'(rd_no), 16'(!(win_d && !c.we)));
      chk(c.dreq ? "R9" : "R10", "wr_n", 16'(wr_no), 16'(!(win_d && c.we)));
      chk("R12", "strobe_overlap", 16'($countones({!psen_no, !rd_no, !wr_no}) > 1), 16'd0);
      exp_oe = fact ? (k <= 2) : c.dreq ? (t <= 2 || c.we) : 1'b0;
      chk(c.dreq ? (c.we ? "R9" : "R8") : "R6", "p0_oe", 16'(p0_oe_o), 16'(exp_oe));
      exp_p0 = fact ? fa[7:0] : (t <= 2) ? c.addr[7:0] : c.wdata;
      if (exp_oe) chk((c.dreq && t > 2) ? "R9" : (c.dreq ? "R3" : "R6"), "p0",
                      16'(p0_o), 16'(exp_p0));
      exp_p2 = fact ? fa[15:8] : (c.dreq && c.wide) ? c.addr[15:8] : p2_latch_i;
      chk("R7", "p2", 16'(p2_o), 16'(exp_p2));
      chk("R6", "fetch_valid", 16'(fetch_valid_o), 16'(fact && k == 5));
      if (fact && k == 5) chk("R6", "fetch_data", 16'(fetch_data_o), 16'(mem(fa)));
      chk("R8", "dacc_valid", 16'(dacc_valid_o), 16'(c.dreq && !c.we && t == 11));
      if (c.dreq && !c.we && t == 11) chk("R8", "rdata", 16'(dacc_rdata_o), 16'(mem(c.addr)));
      // correct byte only inside the strobe window
      byte_v = c.dreq ? mem(c.addr) : mem(fa);
      p0_i = (win_f || (win_d && !c.we)) ? byte_v : ~byte_v;
      if (t == 5) begin
        fetch_req_i  = c.f1;
        fetch_addr_i = c.fa0 + 16'd1;
        dacc_req_i   = 1'b1;          // R10: must be ignored
        dacc_we_i    = ~c.we;
        dacc_addr_i  = 16'hDEAD;
        p2_latch_i   = ~c.p2;
      end
      if (t == 11) drive_first(n);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    p0_i  = 8'h00;
    drive_first(VEC[0]);
    repeat (3) @(negedge clk);
    idle_checks("R11");
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      run_cycle(VEC[i], (i + 1 < NV) ? VEC[i + 1] : VEC[6]);
    // async reset in the middle of a write strobe
    repeat (5) @(negedge clk);
    chk("R9", "wr_n_before_reset", 16'(wr_no), 16'd0);
    rst_n = 1'b0;
    #1;
    idle_checks("R11");
    drive_first(VEC[1]);
    @(negedge clk);
    rst_n = 1'b1;
    run_cycle(VEC[1], VEC[0]);
    run_cycle(VEC[0], VEC[0]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule